// File: doc/BRIEF.md
# Prescaled 8-bit Base Timer

This block is an 8-bit up-counter that advances once per tick of a programmable prescaler fed by the system clock. Three byte-wide registers on a simple CPU register bus control it. The count register can be read and preset. The control register carries an active-low run bit. The mode register selects a divide ratio of 2^(3+m), where m is 0 to 7.

When the count steps from 0xFE to 0xFF, the timer raises a one-cycle overflow pulse for the interrupt controller. The count then wraps through 0x00 and keeps running. Software can preset the count at any moment, including while the timer runs, and counting continues from the written value. Register writes take effect on the clock edge that samples `reg_wr`. Reads are combinational from `reg_addr`.

Top module: `ptick_timer`

## Requirements
- R1: After reset the count reads 0x00, the control register reads 0x01 (stopped), the mode register reads 0x00 and `ovf_pulse` is low.
- R2: A write to address 0x06 loads the count with the write data at that edge, whether the timer is stopped or running. A read of 0x06 returns the count.
- R3: Control bit 0 at address 0x07 runs the timer when 0 and stops it when 1. While stopped the count holds its value. Bits 7:1 of the control register read as 0.
- R4: Mode bits 2:0 at address 0x08 set the tick period to N = 2^(3+m) clocks. With the count at c, the count reads c+1 exactly N clocks after the edge that starts the timer, and then advances once every N clocks.
- R5: The prescaler is cleared while the timer is stopped. After a restart, the first increment again comes a full N clocks after the restart edge, regardless of how far the prescaler had run before the stop.
- R6: `ovf_pulse` is high for exactly one clock, in the cycle in which the count has just stepped from 0xFE to 0xFF. It is low at all other times.
- R7: From 0xFF the next increment yields 0x00 without an overflow pulse, and counting continues.
- R8: A count preset that lands on the same edge as an increment wins: the count takes the written value, not value+1, and the prescaler phase is unchanged.
- R9: A write to any address other than 0x06, 0x07 or 0x08 changes no state. A read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| reg_wr | input | 1 | Write strobe for the register bus, sampled on the rising edge |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ovf_pulse | output | 1 | One-cycle overflow event to the interrupt controller |

## Verification
On every clock, the assertions check the following edge-to-edge rules:
- a preset loads and beats a simultaneous increment;
- a tick adds exactly one;
- without a tick or preset the count is stable;
- the overflow pulse only coincides with 0xFF and never lasts two cycles;
- the wrap from 0xFF is silent;
- the prescaler sits at zero after a stop;
- foreign writes leave the control state alone.

Only the bench scenarios can show the exact tick period for each mode, the full-period restart after a stop, the read-back formats and a preset colliding with a live tick. Random traffic compared against a cycle model covers these as well.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

  localparam int TMR_W      = 8;
  localparam int SEL_W      = 3;
  localparam int BASE_SHIFT = 3;
  localparam int BUS_AW     = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_CTRL,
    SEL_MODE
  } reg_sel_e;

endpackage

// File: rtl/ptick_presc.sv
module ptick_presc #(
  parameter int MODE_W    = 3,
  parameter int MIN_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  output logic              tick
);

  localparam int NMODES = 1 << MODE_W;
  localparam int PS_W   = MIN_SHIFT + NMODES - 1;

  logic [PS_W-1:0] ps_q, ps_d, mask;
  logic            ps_en;

  // Low-order bits that must all be set for a terminal count
  always_comb begin
    for (int i = 0; i < PS_W; i++) begin
      mask[i] = (i < (MIN_SHIFT + int'(mode)));
    end
  end

  always_comb begin
    tick  = run && ((ps_q & mask) == mask);
    ps_d  = run ? (ps_q + 1'b1) : '0;
    ps_en = run || (ps_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ps_q <= '0;
    else if (ps_en) ps_q <= ps_d;
  end

  AST_PS_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ps_q == '0)); // R5

endmodule

// File: rtl/ptick_count.sv
module ptick_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         ovf
);

  localparam logic [W-1:0] TOP_M1 = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en, ovf_q, ovf_d;

  always_comb begin
    cnt_en = load || tick;
    cnt_d  = load ? load_val : (cnt_q + 1'b1);
    ovf_d  = tick && !load && (cnt_q == TOP_M1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q)); // R3
  AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '1)); // R6
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q); // R6
  AST_WRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '1) && tick && !load) |=> ((cnt_q == '0) && !ovf_q)); // R7

endmodule

// File: rtl/ptick_regs.sv
module ptick_regs
  import ptick_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 8,
  parameter int              MODE_W  = 3,
  parameter logic [ADDR_W-1:0] A_COUNT = 8'h06,
  parameter logic [ADDR_W-1:0] A_CTRL  = 8'h07,
  parameter logic [ADDR_W-1:0] A_MODE  = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_val,
  output logic [DATA_W-1:0] rdata,
  output logic              halt,
  output logic [MODE_W-1:0] mode,
  output logic              load,
  output logic [DATA_W-1:0] load_val
);

  reg_sel_e          sel;
  logic              halt_q, halt_d, halt_en;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              mode_en;

  always_comb begin
    if      (addr == A_COUNT) sel = SEL_COUNT;
    else if (addr == A_CTRL)  sel = SEL_CTRL;
    else if (addr == A_MODE)  sel = SEL_MODE;
    else                      sel = SEL_NONE;
  end

  always_comb begin
    halt_en = wr && (sel == SEL_CTRL);
    halt_d  = wdata[0];
    mode_en = wr && (sel == SEL_MODE);
    mode_d  = wdata[MODE_W-1:0];
    load    = wr && (sel == SEL_COUNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      mode_q <= '0;
    end else begin
      if (halt_en) halt_q <= halt_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_COUNT: rdata = cnt_val;
      SEL_CTRL:  rdata[0] = halt_q;
      SEL_MODE:  rdata[MODE_W-1:0] = mode_q;
      default:   rdata = '0;
    endcase
  end

  assign halt     = halt_q;
  assign mode     = mode_q;
  assign load_val = wdata;

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == SEL_NONE)) |=> ($stable(halt_q) && $stable(mode_q))); // R9
  AST_CTRL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == SEL_CTRL)) |=> (halt_q == $past(wdata[0]))); // R3

endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
  import ptick_pkg::*;
#(
  parameter int                CNT_W     = TMR_W,
  parameter int                MODE_W    = SEL_W,
  parameter int                MIN_SHIFT = BASE_SHIFT,
  parameter int                ADDR_W    = BUS_AW,
  parameter logic [ADDR_W-1:0] A_COUNT   = 8'h06,
  parameter logic [ADDR_W-1:0] A_CTRL    = 8'h07,
  parameter logic [ADDR_W-1:0] A_MODE    = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              ovf_pulse
);

  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic              halt, load, tick;
  logic [MODE_W-1:0] mode;
  logic [CNT_W-1:0]  load_val, cnt;

  // Reset asserts at once and is released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  ptick_regs #(
    .ADDR_W (ADDR_W), .DATA_W (CNT_W), .MODE_W (MODE_W),
    .A_COUNT(A_COUNT), .A_CTRL(A_CTRL), .A_MODE(A_MODE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cnt_val (cnt),
    .rdata   (reg_rdata),
    .halt    (halt),
    .mode    (mode),
    .load    (load),
    .load_val(load_val)
  );

  ptick_presc #(.MODE_W(MODE_W), .MIN_SHIFT(MIN_SHIFT)) u_presc (
    .clk  (clk),
    .rst_n(rst_n_s),
    .run  (!halt),
    .mode (mode),
    .tick (tick)
  );

  ptick_count #(.W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (load),
    .load_val(load_val),
    .tick    (tick),
    .cnt     (cnt),
    .ovf     (ovf_pulse)
  );

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (halt && !load) |=> $stable(cnt)); // R3

endmodule

// File: tb/ptick_timer_tb.sv
module ptick_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       ovf_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ptick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_pulse(ovf_pulse)
  );

  // Reference model built from the requirements
  logic [7:0] m_cnt;
  logic       m_halt, m_ovf, m_tk, m_ld;
  logic [2:0] m_mode;
  logic [9:0] m_ps;

  function automatic logic [9:0] pmask(input logic [2:0] m);
    return 10'((11'd1 << (3 + m)) - 11'd1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 8'h00; m_halt <= 1'b1; m_mode <= 3'd0; m_ps <= '0; m_ovf <= 1'b0;
    end else begin
      m_tk = !m_halt && ((m_ps & pmask(m_mode)) == pmask(m_mode));
      m_ld = reg_wr && (reg_addr == 8'h06);
      m_ovf <= m_tk && !m_ld && (m_cnt == 8'hFE);
      m_cnt <= m_ld ? reg_wdata : (m_tk ? m_cnt + 8'd1 : m_cnt);
      m_ps  <= m_halt ? 10'd0 : m_ps + 10'd1;
      if (reg_wr && reg_addr == 8'h07) m_halt <= reg_wdata[0];
      if (reg_wr && reg_addr == 8'h08) m_mode <= reg_wdata[2:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h06;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
    reg_addr = 8'h06;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int         per;
    logic [2:0] modes [3];
    modes[0] = 3'd0; modes[1] = 3'd2; modes[2] = 3'd7;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h06; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h06, v); chk("R1 count", v, 8'h00);
    rd(8'h07, v); chk("R1 control", v, 8'h01);
    rd(8'h08, v); chk("R1 mode", v, 8'h00);
    chk("R1 ovf", ovf_pulse, 1'b0);

    // R9 foreign writes and reads
    wr(8'h05, 8'hFF); wr(8'h09, 8'hFF); wr(8'h0A, 8'h00);
    rd(8'h06, v); chk("R9 count untouched", v, 8'h00);
    rd(8'h07, v); chk("R9 control untouched", v, 8'h01);
    rd(8'h08, v); chk("R9 mode untouched", v, 8'h00);
    rd(8'h05, v); chk("R9 unmapped read", v, 8'h00);

    // R2 preset while stopped, R3 hold while stopped
    wr(8'h06, 8'h5A);
    rd(8'h06, v); chk("R2 preset stopped", v, 8'h5A);
    repeat (40) @(negedge clk);
    rd(8'h06, v); chk("R3 stopped holds", v, 8'h5A);

    // R4 tick period per mode
    foreach (modes[k]) begin
      per = 1 << (3 + modes[k]);
      wr(8'h07, 8'h01); wr(8'h06, 8'h00); wr(8'h08, {5'b0, modes[k]});
      wr(8'h07, 8'hFE);
      rd(8'h07, v); chk("R3 control readback", v, 8'h00);
      repeat (per - 1) @(negedge clk);
      rd(8'h06, v); chk("R4 before first tick", v, 8'h00);
      @(negedge clk);
      rd(8'h06, v); chk("R4 first tick", v, 8'h01);
      repeat (per) @(negedge clk);
      rd(8'h06, v); chk("R4 second tick", v, 8'h02);
    end

    // R5 prescaler restarts after stop (mode 1, N = 16)
    wr(8'h07, 8'h01); wr(8'h06, 8'h00); wr(8'h08, 8'h01); wr(8'h07, 8'h00);
    repeat (16) @(negedge clk);
    rd(8'h06, v); chk("R5 pre-stop tick", v, 8'h01);
    repeat (4) @(negedge clk);
    wr(8'h07, 8'h01);
    repeat (30) @(negedge clk);
    rd(8'h06, v); chk("R3 hold after stop", v, 8'h01);
    wr(8'h07, 8'h00);
    repeat (15) @(negedge clk);
    rd(8'h06, v); chk("R5 no early tick", v, 8'h01);
    @(negedge clk);
    rd(8'h06, v); chk("R5 full period", v, 8'h02);

    // R8 preset colliding with a tick (mode 0, N = 8)
    wr(8'h07, 8'h01); wr(8'h08, 8'h00); wr(8'h06, 8'h10); wr(8'h07, 8'h00);
    repeat (6) @(negedge clk);
    wr(8'h06, 8'h40);
    rd(8'h06, v); chk("R8 preset wins", v, 8'h40);
    repeat (7) @(negedge clk);
    rd(8'h06, v); chk("R8 phase kept", v, 8'h40);
    @(negedge clk);
    rd(8'h06, v); chk("R2 live preset counts on", v, 8'h41);

    // R6 overflow pulse and R7 wrap
    wr(8'h07, 8'h01); wr(8'h06, 8'hFE); wr(8'h07, 8'h00);
    repeat (7) @(negedge clk);
    rd(8'h06, v); chk("R6 count before top", v, 8'hFE);
    chk("R6 no early pulse", ovf_pulse, 1'b0);
    @(negedge clk);
    rd(8'h06, v); chk("R6 count at top", v, 8'hFF);
    chk("R6 pulse high", ovf_pulse, 1'b1);
    @(negedge clk);
    chk("R6 pulse one cycle", ovf_pulse, 1'b0);
    repeat (6) @(negedge clk);
    rd(8'h06, v); chk("R7 still top", v, 8'hFF);
    @(negedge clk);
    rd(8'h06, v); chk("R7 wrap to zero", v, 8'h00);
    chk("R7 quiet wrap", ovf_pulse, 1'b0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 8'h06;
      #1;
      chk("R4 random count", reg_rdata, m_cnt);
      chk("R6 random pulse", ovf_pulse, m_ovf);
      r = $urandom % 24;
      if (r == 0) begin
        reg_wr = 1'b1; reg_addr = 8'h06;
        reg_wdata = ($urandom % 3 == 0) ? 8'(8'hFC + $urandom % 4) : 8'($urandom);
      end else if (r == 1) begin
        reg_wr = 1'b1; reg_addr = 8'h07;
        reg_wdata = ($urandom % 4 == 0) ? 8'h01 : 8'h00;
      end else if (r == 2) begin
        reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 8'($urandom % 3);
      end else if (r == 3) begin
        reg_wr = 1'b1; reg_addr = 8'($urandom % 6); reg_wdata = 8'($urandom);
      end
    end
    @(negedge clk);
    reg_wr = 1'b0;

    summary();
    $finish;
  end

endmodule